// File: doc/BRIEF.md
# Link Power-State Handshake Controller

This block decides when one end of a serial link drops into a low-power state and carries out the command exchange that moves both ends there together. It has two idle counters, one for the light sleep state U1 and one for the deeper state U2. When either counter runs out, the block sends an entry request. It answers requests from the partner with an accept or a reject. After an accept it finishes a three-step exchange: request, accept, acknowledge. The suspend state U3 is entered only when a port in the host role asks for it, and a U3 request can never be refused.

Commands move as one-cycle strobes with a 3-bit code, in each direction. The command channel has no back-pressure. The partner must take every outgoing strobe in the cycle it appears, and every incoming strobe is consumed in the cycle it is sampled. The block reports its power state. When the handshake fails, or when a wake input arrives in a low-power state, it raises a one-cycle recovery request. It then waits for a recovery-done input before it reports U0 again.

Command codes on both channels: 0 none, 1 request U1, 2 request U2, 3 request U3, 4 accept, 5 reject, 6 acknowledge. Power-state codes: 0 U0, 1 U1, 2 U2, 3 U3. All outputs are registered. An input sampled at a clock edge shows its effect on the outputs just after that edge.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, pwr_state is 0 (U0), and cmd_out_vld and recovery_req are low.
- R2: In U0, a U1/U2-capable port sends a request U1 (code 1) in the cycle after link_active has been low for u1_idle_limit consecutive sampled edges. Any high sample of link_active restarts the count, and a limit of 0 disables the counter. When both counters run out together, the U1 request is the one sent.
- R3: With the U1 counter disabled, a capable port sends a request U2 (code 2) directly from U0, u2_idle_limit+1 edges after link activity stops.
- R4: A port with u1u2_capable low never sends a request U1 or request U2, whatever force_accept says.
- R5: In U0, an incoming request U1 or U2 is answered one cycle later. The answer is accept (code 4) when u1u2_capable or force_accept is high, and reject (code 5) otherwise. After a reject the port stays in U0.
- R6: An incoming request U3 is always answered with accept, whatever the capability and force settings.
- R7: A requesting port that receives accept sends acknowledge (code 6) and reports the requested state in the same cycle. A port that receives reject for a U1/U2 request returns to U0 and sends nothing.
- R8: If no accept or reject follows a U1/U2 request within REPLY_CYC cycles, recovery_req pulses for exactly one cycle and pwr_state stays 0.
- R9: A request U3 (code 3) is sent only when host_role and suspend_req are both high in U0. Without host_role, suspend_req has no effect.
- R10: A port that sent a request U3 ignores a reject. If no accept arrives, it enters U3 REPLY_CYC cycles after the request, with no recovery request.
- R11: A port that sent accept enters the agreed state on receiving acknowledge. If acknowledge never arrives, it enters that state ACK_CYC cycles after the accept.
- R12: In U1, the U2 counter restarts at U1 entry. When it runs out, the port moves to U2 u2_idle_limit+1 cycles after entry, with no command sent.
- R13: A wake input in U1, U2 or U3 produces a single one-cycle recovery_req, even if wake is held high. pwr_state keeps the low-power value until recovery_done is seen, and then returns to 0.
- R14: An entry request that arrives while the port's own request is still awaiting a reply is accepted, and the port's own request is dropped. A late accept for the dropped request is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in_vld | input | 1 | Strobe: a command from the partner is present |
| cmd_in_code | input | 3 | Code of the incoming command |
| cmd_out_vld | output | 1 | Strobe: a command to the partner is present |
| cmd_out_code | output | 3 | Code of the outgoing command |
| link_active | input | 1 | High while the link carries traffic in U0 |
| u1_idle_limit | input | TW | Idle cycles before a U1 request; 0 disables |
| u2_idle_limit | input | TW | Idle cycles before U2 entry; 0 disables |
| u1u2_capable | input | 1 | Port supports U1 and U2 |
| force_accept | input | 1 | Incoming U1/U2 requests must be accepted |
| host_role | input | 1 | Port may request U3 |
| suspend_req | input | 1 | Ask for U3 (host role only) |
| wake | input | 1 | Leave the current low-power state |
| recovery_done | input | 1 | Link recovery has completed |
| pwr_state | output | 2 | Current power state, 0..3 for U0..U3 |
| recovery_req | output | 1 | One-cycle request to start link recovery |

## Verification
The bench places each idle-counter expiry on an exact edge. A counter that is off by one, or that activity fails to restart, sends its request one cycle early or late. The bench withholds replies to check both timeout paths. A design that treats a silent U3 request like a U1 request would fire recovery_req instead of entering U3. A design that waits forever on a lost acknowledge would never leave U0. Crossed requests and a held wake input are covered as well. These catch a port that acts on a stale accept after dropping its own request, and a port that pulses recovery_req on every cycle of wake. Capability and forced acceptance are exercised separately, because a swapped condition would refuse a required U3, accept while incapable, or initiate U1 without the capability.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    LC_NONE   = 3'd0,
    LC_REQ_U1 = 3'd1,
    LC_REQ_U2 = 3'd2,
    LC_REQ_U3 = 3'd3,
    LC_ACCEPT = 3'd4,
    LC_REJECT = 3'd5,
    LC_ACK    = 3'd6
  } lcmd_e;

  typedef enum logic [1:0] {
    PS_U0 = 2'd0,
    PS_U1 = 2'd1,
    PS_U2 = 2'd2,
    PS_U3 = 2'd3
  } pstate_e;

  typedef enum logic [2:0] {
    HS_ACTIVE,
    HS_REQ,
    HS_ANS,
    HS_LOW,
    HS_RECOV
  } hs_e;
endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || clr)  cnt_q <= '0;
    else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !clr && (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/lpm_policy.sv
module lpm_policy
  import lpm_pkg::*;
(
  input  logic    in_vld,
  input  logic [2:0] in_code,
  input  logic    capable,
  input  logic    force_acc,
  input  logic    host,
  input  logic    suspend,
  input  logic    u1_exp,
  input  logic    u2_exp,
  output logic    in_req,
  output logic    in_accept,
  output pstate_e in_tgt,
  output logic    own_vld,
  output pstate_e own_tgt
);
  always_comb begin
    in_req    = in_vld && (in_code == LC_REQ_U1 || in_code == LC_REQ_U2 ||
                           in_code == LC_REQ_U3);
    in_tgt    = pstate_e'(in_code[1:0]);
    in_accept = (in_code == LC_REQ_U3) || capable || force_acc;

    own_vld = 1'b0;
    own_tgt = PS_U0;
    if (host && suspend) begin
      own_vld = 1'b1;
      own_tgt = PS_U3;
    end else if (capable && u1_exp) begin
      own_vld = 1'b1;
      own_tgt = PS_U1;
    end else if (capable && u2_exp) begin
      own_vld = 1'b1;
      own_tgt = PS_U2;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TW        = 16,
  parameter int REPLY_CYC = 300,
  parameter int ACK_CYC   = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_in_vld,
  input  logic [2:0]    cmd_in_code,
  output logic          cmd_out_vld,
  output logic [2:0]    cmd_out_code,
  input  logic          link_active,
  input  logic [TW-1:0] u1_idle_limit,
  input  logic [TW-1:0] u2_idle_limit,
  input  logic          u1u2_capable,
  input  logic          force_accept,
  input  logic          host_role,
  input  logic          suspend_req,
  input  logic          wake,
  input  logic          recovery_done,
  output logic [1:0]    pwr_state,
  output logic          recovery_req
);
  localparam int WMAX = (REPLY_CYC > ACK_CYC) ? REPLY_CYC : ACK_CYC;
  localparam int CW   = $clog2(WMAX + 1);

  hs_e     st_q, st_d;
  pstate_e pwr_q, pwr_d, tgt_q, tgt_d;
  logic       ov_q, ov_d, rec_q, rec_d;
  logic [2:0] oc_q, oc_d;

  logic in_u0_idle;
  assign in_u0_idle = (st_q == HS_ACTIVE);

  // idle counters: index 0 drives U1 entry, index 1 drives U2 entry
  logic          idle_run [2];
  logic          idle_clr [2];
  logic [TW-1:0] idle_lim [2];
  logic          idle_exp [2];

  assign idle_run[0] = in_u0_idle;
  assign idle_run[1] = in_u0_idle || (st_q == HS_LOW && pwr_q == PS_U1);
  assign idle_lim[0] = u1_idle_limit;
  assign idle_lim[1] = u2_idle_limit;

  for (genvar gi = 0; gi < 2; gi++) begin : g_idle
    assign idle_clr[gi] = in_u0_idle && link_active;
    lpm_idle_timer #(.TW(TW)) u_idle (
      .clk(clk), .rst_n(rst_n), .run(idle_run[gi]), .clr(idle_clr[gi]),
      .limit(idle_lim[gi]), .expired(idle_exp[gi])
    );
  end

  logic          w_run, w_restart, w_done;
  logic [CW-1:0] w_lim;
  assign w_run     = (st_q == HS_REQ) || (st_q == HS_ANS);
  assign w_restart = (st_d != st_q);
  assign w_lim     = (st_q == HS_REQ) ? CW'(REPLY_CYC) : CW'(ACK_CYC);

  lpm_wait_timer #(.CW(CW)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(w_run), .restart(w_restart),
    .limit(w_lim), .done(w_done)
  );

  logic    in_req, in_accept, own_vld;
  pstate_e in_tgt, own_tgt;

  lpm_policy u_policy (
    .in_vld(cmd_in_vld), .in_code(cmd_in_code), .capable(u1u2_capable),
    .force_acc(force_accept), .host(host_role), .suspend(suspend_req),
    .u1_exp(idle_exp[0]), .u2_exp(idle_exp[1]),
    .in_req(in_req), .in_accept(in_accept), .in_tgt(in_tgt),
    .own_vld(own_vld), .own_tgt(own_tgt)
  );

  logic got_accept, got_reject, got_ack;
  assign got_accept = cmd_in_vld && (cmd_in_code == LC_ACCEPT);
  assign got_reject = cmd_in_vld && (cmd_in_code == LC_REJECT);
  assign got_ack    = cmd_in_vld && (cmd_in_code == LC_ACK);

  always_comb begin
    st_d  = st_q;
    pwr_d = pwr_q;
    tgt_d = tgt_q;
    ov_d  = 1'b0;
    oc_d  = LC_NONE;
    rec_d = 1'b0;
    unique case (st_q)
      HS_ACTIVE: begin
        if (in_req) begin
          ov_d = 1'b1;
          if (in_accept) begin
            oc_d  = LC_ACCEPT;
            tgt_d = in_tgt;
            st_d  = HS_ANS;
          end else begin
            oc_d = LC_REJECT;
          end
        end else if (own_vld) begin
          ov_d  = 1'b1;
          oc_d  = {1'b0, own_tgt};
          tgt_d = own_tgt;
          st_d  = HS_REQ;
        end
      end
      HS_REQ: begin
        if (in_req) begin
          ov_d  = 1'b1;
          oc_d  = LC_ACCEPT;
          tgt_d = in_tgt;
          st_d  = HS_ANS;
        end else if (got_accept) begin
          ov_d  = 1'b1;
          oc_d  = LC_ACK;
          pwr_d = tgt_q;
          st_d  = HS_LOW;
        end else if (got_reject && tgt_q != PS_U3) begin
          st_d = HS_ACTIVE;
        end else if (w_done) begin
          if (tgt_q == PS_U3) begin
            pwr_d = PS_U3;
            st_d  = HS_LOW;
          end else begin
            rec_d = 1'b1;
            st_d  = HS_RECOV;
          end
        end
      end
      HS_ANS: begin
        if (got_ack || w_done) begin
          pwr_d = tgt_q;
          st_d  = HS_LOW;
        end
      end
      HS_LOW: begin
        if (wake) begin
          rec_d = 1'b1;
          st_d  = HS_RECOV;
        end else if (pwr_q == PS_U1 && idle_exp[1]) begin
          pwr_d = PS_U2;
        end
      end
      HS_RECOV: begin
        if (recovery_done) begin
          pwr_d = PS_U0;
          st_d  = HS_ACTIVE;
        end
      end
      default: st_d = HS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= HS_ACTIVE;
      pwr_q <= PS_U0;
      tgt_q <= PS_U0;
      ov_q  <= 1'b0;
      oc_q  <= LC_NONE;
      rec_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pwr_q <= pwr_d;
      tgt_q <= tgt_d;
      ov_q  <= ov_d;
      oc_q  <= oc_d;
      rec_q <= rec_d;
    end
  end

  assign cmd_out_vld  = ov_q;
  assign cmd_out_code = oc_q;
  assign pwr_state    = pwr_q;
  assign recovery_req = rec_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_in_vld,
  input logic [2:0] cmd_in_code,
  input logic       cmd_out_vld,
  input logic [2:0] cmd_out_code,
  input logic       u1u2_capable,
  input logic       force_accept,
  input logic       host_role,
  input logic       recovery_done,
  input logic [1:0] pwr_state,
  input logic       recovery_req,
  input logic       hs_idle
);
  // R13: recovery request lasts one cycle
  p_rec_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_req |=> !recovery_req);

  // R13: leaving a low-power state needs recovery_done
  p_exit_needs_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && $past(pwr_state) != 2'd0) |-> $past(recovery_done));

  // R7: U1 is entered only from U0
  p_u1_from_u0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && $past(pwr_state) != 2'd1) |-> $past(pwr_state) == 2'd0);

  // R12: U2 is reached from U0 or U1 only
  p_u2_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && $past(pwr_state) != 2'd2) |->
      ($past(pwr_state) == 2'd0 || $past(pwr_state) == 2'd1));

  // R4: incapable port never asks for U1 or U2
  p_noncap_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out_vld && (cmd_out_code == 3'd1 || cmd_out_code == 3'd2)) |-> $past(u1u2_capable));

  // R9: only the host asks for U3
  p_u3_host_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out_vld && cmd_out_code == 3'd3) |-> $past(host_role));

  // R6: an incoming U3 request in U0 is always accepted
  p_u3_accepted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && hs_idle && cmd_in_vld && cmd_in_code == 3'd3) |->
      (cmd_out_vld && cmd_out_code == 3'd4));

  // R5: incapable and unforced port rejects U1/U2
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && hs_idle && cmd_in_vld && (cmd_in_code == 3'd1 || cmd_in_code == 3'd2) &&
          !u1u2_capable && !force_accept) |->
      (cmd_out_vld && cmd_out_code == 3'd5 && pwr_state == 2'd0));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_in_vld(cmd_in_vld), .cmd_in_code(cmd_in_code),
  .cmd_out_vld(cmd_out_vld), .cmd_out_code(cmd_out_code),
  .u1u2_capable(u1u2_capable), .force_accept(force_accept), .host_role(host_role),
  .recovery_done(recovery_done), .pwr_state(pwr_state), .recovery_req(recovery_req),
  .hs_idle(in_u0_idle)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int TW = 16;
  localparam int REPLY_CYC = 300;
  localparam int ACK_CYC = 100;

  logic clk = 1'b0;
  logic rst_n, cmd_in_vld, link_active, u1u2_capable, force_accept;
  logic host_role, suspend_req, wake, recovery_done;
  logic [2:0] cmd_in_code;
  logic [TW-1:0] u1_lim, u2_lim;
  logic cmd_out_vld, recovery_req;
  logic [2:0] cmd_out_code;
  logic [1:0] pwr_state;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.TW(TW), .REPLY_CYC(REPLY_CYC), .ACK_CYC(ACK_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_in_vld(cmd_in_vld), .cmd_in_code(cmd_in_code),
    .cmd_out_vld(cmd_out_vld), .cmd_out_code(cmd_out_code), .link_active(link_active),
    .u1_idle_limit(u1_lim), .u2_idle_limit(u2_lim), .u1u2_capable(u1u2_capable),
    .force_accept(force_accept), .host_role(host_role), .suspend_req(suspend_req),
    .wake(wake), .recovery_done(recovery_done), .pwr_state(pwr_state),
    .recovery_req(recovery_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_in_vld = 1'b0; cmd_in_code = 3'd0; link_active = 1'b1;
    u1_lim = '0; u2_lim = '0; u1u2_capable = 1'b1; force_accept = 1'b0;
    host_role = 1'b1; suspend_req = 1'b0; wake = 1'b0; recovery_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] code);
    cmd_in_vld = 1'b1; cmd_in_code = code;
    @(negedge clk);
    cmd_in_vld = 1'b0; cmd_in_code = 3'd0;
  endtask

  task automatic until_cmd(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (cmd_out_vld) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pwr after reset", pwr_state, 0);
    chk("R1 cmd_out after reset", cmd_out_vld, 0);
    chk("R1 recovery after reset", recovery_req, 0);
  endtask

  task automatic t_idle_u1();
    int n;
    int seen = 0;
    do_reset();
    u1_lim = 20; u2_lim = 20;
    link_active = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (cmd_out_vld) seen++;
    end
    chk("R2 no request before limit", seen, 0);
    link_active = 1'b1;
    @(negedge clk);
    link_active = 1'b0;
    until_cmd(100, n);
    chk("R2 request delay after activity restart", n, 21);
    chk("R2 U1 wins over U2", cmd_out_code, 1);
    send(3'd4);
    chk("R7 ack sent on accept", cmd_out_vld && cmd_out_code == 3'd6, 1);
    chk("R7 enters U1 with ack", pwr_state, 1);
  endtask

  task automatic t_u2_direct();
    int n;
    int seen = 0;
    do_reset();
    u2_lim = 30;
    link_active = 1'b0;
    until_cmd(100, n);
    chk("R3 direct U2 delay", n, 31);
    chk("R3 direct U2 code", cmd_out_code, 2);
    send(3'd5);
    chk("R7 nothing sent after reject", cmd_out_vld, 0);
    chk("R7 stays U0 after reject", pwr_state, 0);
    do_reset();
    link_active = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cmd_out_vld) seen++;
    end
    chk("R2 zero limits send nothing", seen, 0);
  endtask

  task automatic t_noncap();
    int seen = 0;
    do_reset();
    u1u2_capable = 1'b0; force_accept = 1'b1; u1_lim = 10; u2_lim = 12;
    link_active = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd_out_vld) seen++;
    end
    chk("R4 incapable port silent", seen, 0);
    force_accept = 1'b0;
    send(3'd1);
    chk("R5 reject when incapable", cmd_out_vld && cmd_out_code == 3'd5, 1);
    chk("R5 stays U0 after rejecting", pwr_state, 0);
    force_accept = 1'b1;
    send(3'd2);
    chk("R5 forced accept", cmd_out_vld && cmd_out_code == 3'd4, 1);
    send(3'd6);
    chk("R11 enters U2 on ack", pwr_state, 2);
  endtask

  task automatic t_u3_incoming();
    int n = 0;
    do_reset();
    u1u2_capable = 1'b0;
    send(3'd3);
    chk("R6 U3 request accepted", cmd_out_vld && cmd_out_code == 3'd4, 1);
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (pwr_state == 2'd3) break;
    end
    chk("R11 U3 entry without ack", n, ACK_CYC);
  endtask

  task automatic t_u3_host();
    int seen = 0;
    int recs = 0;
    int n = 0;
    do_reset();
    host_role = 1'b0; suspend_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmd_out_vld) seen++;
    end
    chk("R9 suspend ignored without host role", seen, 0);
    host_role = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
    chk("R9 host sends U3 request", cmd_out_vld && cmd_out_code == 3'd3, 1);
    while (n < 400) begin
      cmd_in_vld = (n == 9); cmd_in_code = 3'd5;
      @(negedge clk);
      n++;
      if (recovery_req) recs++;
      if (pwr_state == 2'd3) break;
    end
    cmd_in_vld = 1'b0;
    chk("R10 U3 entry on reply timeout", n, REPLY_CYC);
    chk("R10 no recovery for U3", recs, 0);
  endtask

  task automatic t_reply_timeout();
    int n = 0;
    int seen = 0;
    do_reset();
    u1_lim = 5;
    link_active = 1'b0;
    until_cmd(50, n);
    chk("R8 U1 request issued", cmd_out_code, 1);
    link_active = 1'b1;
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (recovery_req) break;
    end
    chk("R8 recovery after reply timeout", n, REPLY_CYC);
    chk("R8 still U0 at timeout", pwr_state, 0);
    @(negedge clk);
    chk("R8 recovery pulse one cycle", recovery_req, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (recovery_req || cmd_out_vld) seen++;
    end
    chk("R8 quiet while recovering", seen, 0);
    recovery_done = 1'b1;
    @(negedge clk);
    recovery_done = 1'b0;
    chk("R8 U0 after recovery", pwr_state, 0);
  endtask

  task automatic t_u1_to_u2();
    int n = 0;
    int seen = 0;
    do_reset();
    u1_lim = 5; u2_lim = 40;
    link_active = 1'b0;
    until_cmd(50, n);
    chk("R12 U1 requested first", cmd_out_code, 1);
    send(3'd4);
    chk("R12 in U1", pwr_state, 1);
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (cmd_out_vld) seen++;
      if (pwr_state == 2'd2) break;
    end
    chk("R12 U1 to U2 delay", n, 41);
    chk("R12 no command for U2 move", seen, 0);
  endtask

  task automatic t_wake();
    int recs = 0;
    do_reset();
    send(3'd1);
    send(3'd6);
    chk("R13 in U1 before wake", pwr_state, 1);
    wake = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (recovery_req) recs++;
    end
    wake = 1'b0;
    chk("R13 single recovery pulse", recs, 1);
    chk("R13 holds U1 until done", pwr_state, 1);
    recovery_done = 1'b1;
    @(negedge clk);
    recovery_done = 1'b0;
    chk("R13 U0 after recovery done", pwr_state, 0);
  endtask

  task automatic t_cross();
    int n;
    do_reset();
    u1_lim = 5;
    link_active = 1'b0;
    until_cmd(50, n);
    chk("R14 own request sent", cmd_out_code, 1);
    link_active = 1'b1;
    send(3'd2);
    chk("R14 incoming request accepted", cmd_out_vld && cmd_out_code == 3'd4, 1);
    send(3'd4);
    chk("R14 stale accept ignored: no output", cmd_out_vld, 0);
    chk("R14 stale accept ignored: still U0", pwr_state, 0);
    send(3'd6);
    chk("R14 enters incoming target", pwr_state, 2);
  endtask

  initial begin
    rst_n = 1'b0; cmd_in_vld = 1'b0; cmd_in_code = 3'd0; link_active = 1'b1;
    u1_lim = '0; u2_lim = '0; u1u2_capable = 1'b1; force_accept = 1'b0;
    host_role = 1'b0; suspend_req = 1'b0; wake = 1'b0; recovery_done = 1'b0;
    t_reset();
    t_idle_u1();
    t_u2_direct();
    t_noncap();
    t_u3_incoming();
    t_u3_host();
    t_reply_timeout();
    t_u1_to_u2();
    t_wake();
    t_cross();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule